// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Controller

This block runs one cache line refill at a time against a memory port that returns one data word per beat. A miss request carries the line address, the index of the word the stalled processor is waiting for, and a burst ordering flag. The controller issues a single burst read and stores every returned word into a line buffer. It releases the requested word to the processor as soon as that word arrives, and then keeps filling the rest of the line in the background.

Two orderings are supported. In wrapped mode the burst begins at the requested word and wraps around the end of the line, so the processor is released after the first beat. In linear mode the burst begins at word zero and the processor is released on the beat that happens to carry the requested word. When the last word has been stored, a one-cycle completion strobe presents the whole assembled line so that it can be written into the cache arrays. A new miss is held off with a busy flag until that strobe.

Top module: `cwf_fill_ctrl`

## Requirements
- R1: After reset, busy, mem_req_valid, cpu_valid and line_done are all 0.
- R2: A miss is accepted on a rising edge where miss_valid is 1 and busy is 0. Busy is 1 from the next cycle up to, but not including, the cycle in which line_done is 1. A miss presented while busy is 1 is ignored and issues no new memory request.
- R3: After a miss is accepted, mem_req_valid is 1 with mem_req_addr equal to the line address. It stays 1 with all request fields unchanged until a cycle in which mem_req_ready is 1. mem_req_wrap is 1 for wrapped mode (miss_wrap=1) and 0 for linear mode. mem_req_first is the missed word index in wrapped mode and 0 in linear mode.
- R4: In wrapped mode, the k-th accepted beat (k counting from 0) is stored as word (missed_index + k) mod WORDS of the line.
- R5: In linear mode, the k-th accepted beat is stored as word k of the line.
- R6: cpu_valid is 1 for exactly one cycle per refill: the cycle after the beat that carries the missed word. cpu_data then equals that beat's data. In wrapped mode this is the cycle after the first beat.
- R7: The refill continues after the release. line_done is 1 for exactly one cycle, the cycle after the WORDS-th beat. In that cycle line_data holds every word, with word i at bits [i*DATA_W +: DATA_W], and line_addr holds the line address.
- R8: A cycle with mem_beat_valid at 0 stores nothing. A beat presented while no refill is waiting for data (idle or request phase) is ignored and produces neither cpu_valid nor line_done.
- R9: WORDS is a parameter (default 8), and it must be a power of two of at least 2. DATA_W and the line address width are also parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_line_addr | input | LA_W | Line address of the miss |
| miss_word | input | log2(WORDS) | Index of the word the processor needs |
| miss_wrap | input | 1 | 1 = wrapped critical-first burst, 0 = linear burst |
| busy | output | 1 | Refill in progress; misses are not accepted |
| mem_req_valid | output | 1 | Burst read request to memory |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | LA_W | Line address of the burst |
| mem_req_first | output | log2(WORDS) | Word index of the first beat |
| mem_req_wrap | output | 1 | Burst wraps around the line end |
| mem_beat_valid | input | 1 | A returned data beat is present |
| mem_beat_data | input | DATA_W | Returned data word |
| cpu_valid | output | 1 | Missed word released to the processor |
| cpu_data | output | DATA_W | The missed word |
| line_done | output | 1 | One-cycle strobe: line fully assembled |
| line_addr | output | LA_W | Line address accompanying line_done |
| line_data | output | WORDS*DATA_W | The assembled line, word i at bits [i*DATA_W +: DATA_W] |

## Verification
The assertions assume that memory returns exactly WORDS beats for each accepted request, in the order that the request fields describe, and only after the request is taken. The stimulus follows this rule. Its memory model answers each request with exactly one line of beats, ordered from the request's first index and wrap flag, and it inserts idle gaps between beats but never extra beats. Stray beats are driven only while no request is waiting for data, to check that they are ignored.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_FILL = 2'd2
   } fill_state_e;
endpackage

// File: rtl/cwf_beat_seq.sv
module cwf_beat_seq #(
   parameter int WORDS = 8,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             beat,
   input  logic [IDX_W-1:0] crit,
   input  logic             wrap,
   output logic [IDX_W-1:0] idx,
   output logic             last
);
   logic [IDX_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt_q <= '0;
      else if (beat)       cnt_q <= cnt_q + 1'b1;
   end

   // The power-of-two line length lets the wrap come from truncating the sum.
   always_comb begin
      idx  = wrap ? IDX_W'(crit + cnt_q) : cnt_q;
      last = (cnt_q == IDX_W'(WORDS - 1));
   end

   AST_WRAP_FIRST_IS_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && wrap && cnt_q == '0) |-> (idx == crit)); // R4
   AST_LINEAR_FIRST_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !wrap && cnt_q == '0) |-> (idx == '0)); // R5
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
   parameter int WORDS  = 8,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [IDX_W-1:0]        widx,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [IDX_W-1:0]        ridx,
   output logic [DATA_W-1:0]       rdata,
   output logic [WORDS*DATA_W-1:0] line
);
   logic [DATA_W-1:0] word_q [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (we && widx == IDX_W'(w)) word_q[w] <= wdata;
      end
      assign line[w*DATA_W +: DATA_W] = word_q[w];
   end

   assign rdata = word_q[ridx];
endmodule

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl #(
   parameter int WORDS  = 8,
   parameter int DATA_W = 32,
   parameter int LA_W   = 26,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    miss_valid,
   input  logic [LA_W-1:0]         miss_line_addr,
   input  logic [IDX_W-1:0]        miss_word,
   input  logic                    miss_wrap,
   output logic                    busy,
   output logic                    mem_req_valid,
   input  logic                    mem_req_ready,
   output logic [LA_W-1:0]         mem_req_addr,
   output logic [IDX_W-1:0]        mem_req_first,
   output logic                    mem_req_wrap,
   input  logic                    mem_beat_valid,
   input  logic [DATA_W-1:0]       mem_beat_data,
   output logic                    cpu_valid,
   output logic [DATA_W-1:0]       cpu_data,
   output logic                    line_done,
   output logic [LA_W-1:0]         line_addr,
   output logic [WORDS*DATA_W-1:0] line_data
);
   import cwf_pkg::*;

   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("cwf_fill_ctrl: WORDS must be a power of two, at least 2"); // R9
   end
   if (DATA_W < 1 || LA_W < 1) begin : g_bad_widths
      $error("cwf_fill_ctrl: DATA_W and LA_W must be positive");
   end

   fill_state_e      state_q;
   logic [LA_W-1:0]  addr_q;
   logic [IDX_W-1:0] crit_q;
   logic             wrap_q;
   logic             released_q;
   logic             cpu_valid_q;
   logic [DATA_W-1:0] cpu_data_q;
   logic             done_q;

   logic             accept;
   logic             beat;
   logic [IDX_W-1:0] beat_idx;
   logic             beat_last;
   logic [DATA_W-1:0] crit_word;

   assign busy   = (state_q != ST_IDLE);
   assign accept = miss_valid && !busy;
   assign beat   = (state_q == ST_FILL) && mem_beat_valid;

   cwf_beat_seq #(.WORDS(WORDS)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .beat  (beat),
      .crit  (crit_q),
      .wrap  (wrap_q),
      .idx   (beat_idx),
      .last  (beat_last)
   );

   cwf_line_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
      .clk   (clk),
      .we    (beat),
      .widx  (beat_idx),
      .wdata (mem_beat_data),
      .ridx  (crit_q),
      .rdata (crit_word),
      .line  (line_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         crit_q      <= '0;
         wrap_q      <= 1'b0;
         released_q  <= 1'b0;
         cpu_valid_q <= 1'b0;
         cpu_data_q  <= '0;
         done_q      <= 1'b0;
      end else begin
         cpu_valid_q <= 1'b0;
         done_q      <= 1'b0;
         case (state_q)
            ST_IDLE: if (accept) begin
               state_q    <= ST_REQ;
               addr_q     <= miss_line_addr;
               crit_q     <= miss_word;
               wrap_q     <= miss_wrap;
               released_q <= 1'b0;
            end
            ST_REQ: if (mem_req_ready) state_q <= ST_FILL;
            ST_FILL: if (beat) begin
               if (beat_idx == crit_q) begin
                  cpu_valid_q <= 1'b1;
                  cpu_data_q  <= mem_beat_data;
                  released_q  <= 1'b1;
               end
               if (beat_last) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (state_q == ST_REQ);
   assign mem_req_addr  = addr_q;
   assign mem_req_first = wrap_q ? crit_q : '0;
   assign mem_req_wrap  = wrap_q;
   assign cpu_valid     = cpu_valid_q;
   assign cpu_data      = cpu_data_q;
   assign line_done     = done_q;
   assign line_addr     = addr_q;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_first) && $stable(mem_req_wrap))); // R3
   AST_CPU_MATCHES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid |-> (cpu_data == crit_word)); // R6
   AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid |-> !$past(released_q)); // R6
   AST_RELEASE_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |-> released_q); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |=> !line_done); // R7
   AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |-> !busy); // R2
   AST_NO_STRAY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !line_done) |=> !cpu_valid); // R8
endmodule

// File: tb/tb_cwf_fill_ctrl.sv
`timescale 1ns/1ps
module tb_cwf_fill_ctrl;
   localparam int WORDS  = 8;
   localparam int DATA_W = 32;
   localparam int LA_W   = 26;
   localparam int IDX_W  = $clog2(WORDS);

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    miss_valid = 1'b0;
   logic [LA_W-1:0]         miss_line_addr = '0;
   logic [IDX_W-1:0]        miss_word = '0;
   logic                    miss_wrap = 1'b0;
   logic                    busy;
   logic                    mem_req_valid;
   logic                    mem_req_ready = 1'b0;
   logic [LA_W-1:0]         mem_req_addr;
   logic [IDX_W-1:0]        mem_req_first;
   logic                    mem_req_wrap;
   logic                    mem_beat_valid = 1'b0;
   logic [DATA_W-1:0]       mem_beat_data = '0;
   logic                    cpu_valid;
   logic [DATA_W-1:0]       cpu_data;
   logic                    line_done;
   logic [LA_W-1:0]         line_addr;
   logic [WORDS*DATA_W-1:0] line_data;

   always #2.5 clk = ~clk;

   cwf_fill_ctrl #(.WORDS(WORDS), .DATA_W(DATA_W), .LA_W(LA_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_line_addr(miss_line_addr),
      .miss_word(miss_word), .miss_wrap(miss_wrap), .busy(busy),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_first(mem_req_first),
      .mem_req_wrap(mem_req_wrap),
      .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
      .cpu_valid(cpu_valid), .cpu_data(cpu_data),
      .line_done(line_done), .line_addr(line_addr), .line_data(line_data)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [DATA_W-1:0]       cpu_q  [$];
   logic [WORDS*DATA_W-1:0] line_q [$];
   logic [LA_W-1:0]         addr_q [$];
   bit cpu_seen = 1'b0;

   task automatic check(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] word_val(input logic [LA_W-1:0] a, input int i);
      return DATA_W'({a[15:0], 16'h0}) ^ DATA_W'(32'h00C0_0000 + i * 32'h0101);
   endfunction

   // Monitor: pops expectations as results appear.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (cpu_valid) begin
            if (cpu_q.size() == 0) check("R6", "unexpected cpu_valid", 1, 0);
            else check("R6", "cpu_data", cpu_data, cpu_q.pop_front());
            cpu_seen = 1'b1;
         end
         if (line_done) begin
            if (line_q.size() == 0) check("R7", "unexpected line_done", 1, 0);
            else begin
               check("R7", "line_data", line_data, line_q.pop_front());
               check("R7", "line_addr", line_addr, addr_q.pop_front());
               check("R7", "released before or with done", cpu_seen, 1);
            end
            cpu_seen = 1'b0;
         end
      end
   end

   task automatic do_fill(input logic [LA_W-1:0] a, input int crit, input bit wrap,
                          input int gap, input bit poke);
      logic [WORDS*DATA_W-1:0] exp_line;
      int idx;
      for (int i = 0; i < WORDS; i++) exp_line[i*DATA_W +: DATA_W] = word_val(a, i);
      @(posedge clk); #1;
      miss_valid = 1'b1; miss_line_addr = a; miss_word = IDX_W'(crit); miss_wrap = wrap;
      @(posedge clk); #1;
      miss_valid = 1'b0;
      @(negedge clk);
      check("R2", "busy after accept", busy, 1);
      check("R3", "req valid", mem_req_valid, 1);
      check("R3", "req addr", mem_req_addr, a);
      check("R3", "req wrap", mem_req_wrap, wrap);
      check("R3", "req first", mem_req_first, wrap ? crit : 0);
      // Stray beat during request phase must be ignored (R8).
      mem_beat_valid = 1'b1; mem_beat_data = 32'hDEAD_BEEF;
      @(posedge clk); #1;
      mem_beat_valid = 1'b0;
      @(negedge clk);
      check("R3", "req still held", mem_req_valid, 1);
      check("R3", "req addr held", mem_req_addr, a);
      check("R8", "no release in request phase", cpu_valid, 0);
      mem_req_ready = 1'b1;
      @(posedge clk); #1;
      mem_req_ready = 1'b0;
      cpu_q.push_back(word_val(a, crit));
      line_q.push_back(exp_line);
      addr_q.push_back(a);
      for (int k = 0; k < WORDS; k++) begin
         for (int g = 0; g < gap; g++) begin
            @(posedge clk); #1;
         end
         idx = wrap ? (crit + k) % WORDS : k;
         mem_beat_valid = 1'b1;
         mem_beat_data  = word_val(a, idx);
         if (poke && k == 1) begin
            miss_valid = 1'b1; miss_line_addr = a + 1; miss_word = '0;
         end
         @(posedge clk); #1;
         mem_beat_valid = 1'b0;
         miss_valid = 1'b0;
         @(negedge clk);
         check(wrap ? "R4" : "R5", "cpu_valid timing", cpu_valid, idx == crit);
         if (k < WORDS - 1) check("R7", "no early done", line_done, 0);
         if (k < WORDS - 1) check("R2", "busy during fill", busy, 1);
      end
      check("R7", "line_done after last beat", line_done, 1);
      check("R2", "busy low with done", busy, 0);
      @(posedge clk); #1;
      @(negedge clk);
      check("R7", "done one cycle", line_done, 0);
      check("R2", "no request from ignored miss", mem_req_valid, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      @(negedge clk);
      check("R1", "busy in reset", busy, 0);
      check("R1", "req in reset", mem_req_valid, 0);
      check("R1", "cpu_valid in reset", cpu_valid, 0);
      check("R1", "line_done in reset", line_done, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      mem_beat_valid = 1'b1; mem_beat_data = 32'h1234_5678;
      @(posedge clk); #1;
      mem_beat_valid = 1'b0;
      @(negedge clk);
      check("R8", "idle beat no release", cpu_valid, 0);
      check("R8", "idle beat no done", line_done, 0);
      check("R1", "idle not busy", busy, 0);
      do_fill(26'h012_3450, 5, 1'b1, 0, 1'b0);
      do_fill(26'h00A_BCD0, 5, 1'b0, 2, 1'b0);
      do_fill(26'h3FF_0010, 0, 1'b1, 1, 1'b0);
      do_fill(26'h155_5550, 7, 1'b0, 0, 1'b0);
      do_fill(26'h0F0_F0F0, 0, 1'b0, 0, 1'b1);
      do_fill(26'h2AA_AAA0, 7, 1'b1, 3, 1'b1);
      repeat (3) @(posedge clk);
      check("R6", "all releases seen", cpu_q.size(), 0);
      check("R7", "all lines seen", line_q.size(), 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         checks++;
         errors++;
         finished = 1'b1;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule